// File: doc/BRIEF.md
# Protection Region Bounds Decoder

This block turns the per-entry configuration of a physical memory protection table into explicit byte ranges. For every entry it takes a 2-bit matching mode, the entry's own address register and the address register of the entry just below it, and produces an inclusive lowest and highest byte address. Every entry is decoded in parallel with pure combinational logic. A range checker placed after this block can then compare each access against plain bounds and never has to interpret the mode encodings.

Address registers hold a byte address divided by four. The decoded bounds are two bits wider than the address registers, so a region that covers the whole space is still representable. The block also reports how many entries have a mode other than OFF. A permission checker can use this count to skip the table when no entry is active.

Top module: `prb_bounds_decoder`

## Requirements
- R1: Mode code 0 (OFF) gives a lowest address of 0 and a highest address of all ones at XLEN+2 bits.
- R2: Mode code 1 (top of range) gives a lowest address equal to the previous entry's register times four, and a highest address equal to this entry's register times four minus one. Entry 0 treats its previous register as zero.
- R3: In top-of-range mode, when the computed lowest address is greater than the computed highest address, both outputs are zero.
- R4: In top-of-range mode, the highest address is computed modulo 2^(XLEN+2). A zero register therefore gives an all-ones highest address.
- R5: Mode code 2 (four-byte region) gives a lowest address equal to the register times four and a highest address three above it.
- R6: Mode code 3 (power-of-two region) with k trailing one bits in the register gives an aligned region of 2^(k+3) bytes that contains the register times four.
- R7: In mode code 3, a register with XLEN or XLEN-1 trailing ones gives the whole space, from 0 to all ones at XLEN+2 bits, with no wrap-around.
- R8: The active count equals the number of entries whose mode code is not 0. Entry i's mode occupies bits [2i+1:2i] of the mode vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_vec | input | 2*N | Matching mode of each entry, entry i at bits [2i+1:2i] |
| addr_vec | input | N*XLEN | Address register of each entry, entry i at bits [i*XLEN +: XLEN] |
| start_vec | output | N*(XLEN+2) | Inclusive lowest byte address of each entry |
| end_vec | output | N*(XLEN+2) | Inclusive highest byte address of each entry |
| active_cnt | output | $clog2(N+1) | Number of entries whose mode is not OFF |

## Verification
The embedded checks look at the shape of every decoded range whenever the inputs change. OFF ranges must span everything. Top-of-range ranges must never be inverted. Four-byte ranges must be exactly four bytes wide. Power-of-two ranges must have a power-of-two size and be aligned to that size.

Those shape checks cannot show that a range sits in the right place. Correct endpoints, the chaining to the previous entry, the empty-range rule, the wrap of a zero register and the whole-space cases are shown only by the bench. It sweeps every mode and register combination of a small configuration and compares each result with arithmetic computed independently.

// File: rtl/prb_pkg.sv
// Package: shared mode encoding for the protection region bounds decoder.
// Assumes the 2-bit mode field uses the encodings listed below.
package prb_pkg;

    typedef enum logic [1:0] {
        RM_OFF   = 2'd0,
        RM_TOR   = 2'd1,
        RM_NA4   = 2'd2,
        RM_NAPOT = 2'd3
    } region_mode_e;

endpackage

// File: rtl/prb_entry_dec.sv
// Module: prb_entry_dec
// Decodes one protection entry into inclusive byte bounds at XLEN+2 bits.
// Assumes the address registers hold byte address bits [XLEN+1:2].
// The logic is purely combinational.
module prb_entry_dec
    import prb_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]        mode_i,
    input  logic [XLEN-1:0]   addr_cur_i,
    input  logic [XLEN-1:0]   addr_prev_i,
    output logic [XLEN+1:0]   start_o,
    output logic [XLEN+1:0]   end_o
);
    localparam int W = XLEN + 2;

    region_mode_e  mode;
    logic [W-1:0]  base_cur;
    logic [W-1:0]  base_prev;
    logic [W-1:0]  napot_v;
    logic [W-1:0]  napot_inc;
    logic [W-1:0]  span;

    // Select the bounds for the mode and check the shape of the result.
    always_comb begin : decode_bounds
        mode      = region_mode_e'(mode_i);
        base_cur  = {addr_cur_i, 2'b00};
        base_prev = {addr_prev_i, 2'b00};
        napot_v   = base_cur | W'(3);
        napot_inc = napot_v + W'(1);
        unique case (mode)
            RM_OFF: begin
                start_o = '0;
                end_o   = '1;
            end
            RM_TOR: begin
                start_o = base_prev;
                end_o   = base_cur - W'(1);
                if (start_o > end_o) begin
                    start_o = '0;
                    end_o   = '0;
                end
            end
            RM_NA4: begin
                start_o = base_cur;
                end_o   = base_cur | W'(3);
            end
            default: begin
                start_o = napot_v & napot_inc;
                end_o   = napot_v | napot_inc;
            end
        endcase
        span = end_o - start_o;

        if (mode == RM_OFF) begin
            a_r1_off_full: assert ((start_o == '0) && (&end_o))
                else $error("OFF entry does not span the whole space");
        end
        if (mode == RM_TOR) begin
            a_r3_tor_order: assert (start_o <= end_o)
                else $error("top-of-range bounds inverted");
        end
        if (mode == RM_NA4) begin
            a_r5_na4_width: assert (span == W'(3))
                else $error("four-byte region has wrong width");
        end
        if (mode == RM_NAPOT) begin
            a_r6_napot_pow2: assert ((((span + W'(1)) & span) == '0) && ((start_o & span) == '0))
                else $error("power-of-two region not aligned");
        end
    end

endmodule

// File: rtl/prb_active_count.sv
// Module: prb_active_count
// Counts the entries whose mode field is not OFF.
// Assumes entry i's mode sits at bits [2i+1:2i] of the input vector.
module prb_active_count #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [2*N-1:0] mode_vec_i,
    output logic [CW-1:0]  count_o
);
    logic any_on;

    // Sum the active entries and check the count against the any-active flag.
    always_comb begin : count_active
        count_o = '0;
        any_on  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (mode_vec_i[2*i +: 2] != 2'd0) begin
                count_o = count_o + CW'(1);
                any_on  = 1'b1;
            end
        end
        a_r8_count_range: assert ((count_o <= CW'(N)) && ((count_o != '0) == any_on))
            else $error("active count inconsistent");
    end

endmodule

// File: rtl/prb_bounds_decoder.sv
// Module: prb_bounds_decoder (top)
// Decodes every entry of a protection table into inclusive byte bounds.
// Also reports the number of active entries.
// Assumes flat packed vectors, with entry i in slice i of each vector.
module prb_bounds_decoder #(
    parameter int XLEN = 32,
    parameter int N    = 16,
    parameter int W    = XLEN + 2,
    parameter int CW   = $clog2(N + 1)
) (
    input  logic [2*N-1:0]    mode_vec,
    input  logic [N*XLEN-1:0] addr_vec,
    output logic [N*W-1:0]    start_vec,
    output logic [N*W-1:0]    end_vec,
    output logic [CW-1:0]     active_cnt
);

    // One decoder per entry, chained to the previous entry's register.
    for (genvar gi = 0; gi < N; gi++) begin : g_entry
        logic [XLEN-1:0] prev_addr;
        if (gi == 0) begin : g_first
            assign prev_addr = '0;
        end else begin : g_chain
            assign prev_addr = addr_vec[(gi-1)*XLEN +: XLEN];
        end
        prb_entry_dec #(.XLEN(XLEN)) u_dec (
            .mode_i      (mode_vec[2*gi +: 2]),
            .addr_cur_i  (addr_vec[gi*XLEN +: XLEN]),
            .addr_prev_i (prev_addr),
            .start_o     (start_vec[gi*W +: W]),
            .end_o       (end_vec[gi*W +: W])
        );
    end

    prb_active_count #(.N(N), .CW(CW)) u_count (
        .mode_vec_i (mode_vec),
        .count_o    (active_cnt)
    );

endmodule

// File: tb/prb_bounds_decoder_tb.sv
// Bench: sweeps all modes and register values of a 4-bit, 3-entry build.
// The expected bounds are computed arithmetically here.
module prb_bounds_decoder_tb_top;
    localparam int XLEN = 4;
    localparam int N    = 3;
    localparam int W    = XLEN + 2;
    localparam int CW   = $clog2(N + 1);
    localparam int MASK = (1 << W) - 1;

    logic clk = 1'b0;
    logic [2*N-1:0]    mode_vec = '0;
    logic [N*XLEN-1:0] addr_vec = '0;
    logic [N*W-1:0]    start_vec;
    logic [N*W-1:0]    end_vec;
    logic [CW-1:0]     active_cnt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    prb_bounds_decoder #(.XLEN(XLEN), .N(N)) dut_i (
        .mode_vec   (mode_vec),
        .addr_vec   (addr_vec),
        .start_vec  (start_vec),
        .end_vec    (end_vec),
        .active_cnt (active_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected bounds from the requirements; also names the requirement.
    task automatic expect_bounds(input int mode, input int cur, input int prev,
                                 output int lo, output int hi, output string req);
        int k;
        int size;
        case (mode)
            0: begin lo = 0; hi = MASK; req = "R1"; end
            1: begin
                lo = prev * 4;
                hi = (cur * 4 - 1) & MASK;
                req = (cur == 0) ? "R4" : "R2";
                if (lo > hi) begin lo = 0; hi = 0; req = "R3"; end
            end
            2: begin lo = cur * 4; hi = cur * 4 + 3; req = "R5"; end
            default: begin
                k = 0;
                while (k < XLEN && ((cur >> k) & 1) == 1) k++;
                size = 1 << (k + 3);
                lo = (cur * 4) & ~(size - 1) & MASK;
                hi = (lo + size - 1) & MASK;
                req = (k >= XLEN - 1) ? "R7" : "R6";
            end
        endcase
    endtask

    task automatic check_entry(input int e, input int mode, input int cur, input int prev);
        int lo;
        int hi;
        string req;
        expect_bounds(mode, cur, prev, lo, hi, req);
        chk({req, " start"}, int'(start_vec[e*W +: W]), lo);
        chk({req, " end"},   int'(end_vec[e*W +: W]),   hi);
    endtask

    initial begin : stimulus
        // Full sweep: entry 1 over every mode and both registers.
        for (int m1 = 0; m1 < 4; m1++) begin
            for (int a1 = 0; a1 < 16; a1++) begin
                for (int a0 = 0; a0 < 16; a0++) begin
                    int m0;
                    m0 = (a1 ^ a0) & 3;
                    @(posedge clk);
                    mode_vec = {2'(m1), 2'(m1), 2'(m0)};
                    addr_vec = {4'(a0), 4'(a1), 4'(a0)};
                    @(negedge clk);
                    check_entry(0, m0, a0, 0);
                    check_entry(1, m1, a1, a0);
                    check_entry(2, m1, a0, a1);
                end
            end
        end
        // R8: every mode combination, counted in the bench.
        for (int mv = 0; mv < 64; mv++) begin
            int n_on;
            @(posedge clk);
            mode_vec = 6'(mv);
            addr_vec = '0;
            @(negedge clk);
            n_on = 0;
            for (int i = 0; i < N; i++) if (((mv >> (2*i)) & 3) != 0) n_on++;
            chk("R8 count", int'(active_cnt), n_on);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule